// File: doc/BRIEF.md
# Pipeline Stall and Load Interlock Controller

This block is the central hold logic of a three-stage pipeline. Stage 0 holds the fetched opcode, stage 1 does the ALU work and drives memory addresses, and stage 2 takes load data back into the register file. The block combines three stall sources into one hold bit per stage and a code-fetch valid strobe. The sources are an external memory wait, a multiply/divide busy flag, and a load sitting in stage 1.

A load raises a one-cycle interlock. During that cycle the front stages freeze and the fetch strobe drops, while the last stage keeps moving, so the loaded word still reaches the register file. The interlock is raised after every load, whether or not the next instruction reads the loaded register. A memory wait or a multiply/divide freezes every stage. An interlock that meets such a freeze is deferred and serves its single cycle once the freeze ends. A parameter removes the interlock completely, which leaves the software to fill the load delay slot. Two registered status flags report the stall condition and the cycle that follows a served interlock.

Top module: `pstall_ctrl`

## Requirements
- R1: While `mem_wait` is 1, every bit of `hold_o` is 1 and `code_vma` is 0.
- R2: While `md_busy` is 1, every bit of `hold_o` is 1 and `code_vma` is 0.
- R3: With the interlock enabled, `ld_s1` at 1, `ilock_q` at 0 and neither freeze source active, `hold_o` is 3'b011 (bit i holds stage i) and `code_vma` is 0 for that cycle.
- R4: In the cycle after a served interlock cycle, `ilock_q` is 1 and the interlock is not raised again, even if `ld_s1` is still 1. The holds are then 0 and `code_vma` is 1 unless a freeze source is active.
- R5: An interlock that meets a freeze is not served. It keeps being requested and completes one cycle after the freeze ends.
- R6: With the interlock disabled by parameter, `ld_s1` has no effect on `hold_o`, `code_vma` or `ilock_q`.
- R7: `stall_q` equals the OR of `mem_wait` and `md_busy` from the previous cycle.
- R8: After reset, `stall_q` and `ilock_q` are 0. With all inputs at 0, `hold_o` is 0 and `code_vma` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_wait | input | 1 | Memory system wait; freezes all stages |
| md_busy | input | 1 | Multiply/divide in progress; freezes all stages |
| ld_s1 | input | 1 | A load instruction is in stage 1 |
| hold_o | output | NSTAGE | Per-stage hold, bit i for stage i |
| code_vma | output | 1 | Code-read address valid strobe |
| stall_q | output | 1 | Registered: a freeze source was active last cycle |
| ilock_q | output | 1 | Registered: an interlock was served last cycle |

## Verification
An interlock request and a freeze can arrive in the same cycle. The bench provokes this with directed sequences: a load is raised while `mem_wait` or `md_busy` is already high, and then the wait is dropped. Random stimulus also overlaps all three inputs often. A bench reference model judges each cycle. It expects a full freeze with no interlock served while the freeze lasts, and then exactly one cycle of the 3'b011 pattern before the front stages are released.

// File: rtl/pstall_pkg.sv
package pstall_pkg;
    typedef struct packed {
        logic served;
    } lock_st_t;

    typedef struct packed {
        logic stall;
    } stat_t;
endpackage

// File: rtl/pstall_lock.sv
module pstall_lock
    import pstall_pkg::*;
#(
    parameter bit INTERLOCK_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_s1,
    input  logic freeze,
    output logic lock_req,
    output logic served_q
);
    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        lock_req = INTERLOCK_EN && ld_s1 && !st_q.served;
        // an interlock cycle counts only when nothing else freezes the pipe
        st_d.served = lock_req && !freeze;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign served_q = st_q.served;
endmodule

// File: rtl/pstall_hold.sv
module pstall_hold #(
    parameter int NSTAGE = 3
) (
    input  logic              freeze,
    input  logic              lock_req,
    output logic [NSTAGE-1:0] hold_o,
    output logic              code_vma
);
    localparam int WB_STAGE = NSTAGE - 1;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        if (i < WB_STAGE) begin : g_front
            assign hold_o[i] = freeze | lock_req;
        end else begin : g_back
            assign hold_o[i] = freeze;
        end
    end

    assign code_vma = ~hold_o[0];
endmodule

// File: rtl/pstall_ctrl.sv
module pstall_ctrl
    import pstall_pkg::*;
#(
    parameter bit INTERLOCK_EN = 1'b1,
    parameter int NSTAGE       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_wait,
    input  logic              md_busy,
    input  logic              ld_s1,
    output logic [NSTAGE-1:0] hold_o,
    output logic              code_vma,
    output logic              stall_q,
    output logic              ilock_q
);
    logic  freeze;
    logic  lock_req;
    stat_t stat_d, stat_q;

    assign freeze = mem_wait | md_busy;

    pstall_lock #(.INTERLOCK_EN(INTERLOCK_EN)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_s1    (ld_s1),
        .freeze   (freeze),
        .lock_req (lock_req),
        .served_q (ilock_q)
    );

    pstall_hold #(.NSTAGE(NSTAGE)) u_hold (
        .freeze   (freeze),
        .lock_req (lock_req),
        .hold_o   (hold_o),
        .code_vma (code_vma)
    );

    always_comb begin
        stat_d = stat_q;
        stat_d.stall = freeze;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stall_q = stat_q.stall;
endmodule

// File: rtl/pstall_ctrl_chk.sv
module pstall_ctrl_chk #(
    parameter bit INTERLOCK_EN = 1'b1,
    parameter int NSTAGE       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_wait,
    input logic              md_busy,
    input logic              ld_s1,
    input logic [NSTAGE-1:0] hold_o,
    input logic              code_vma,
    input logic              stall_q,
    input logic              ilock_q
);
    localparam int WB = NSTAGE - 1;

    // R1
    memwait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wait |-> (&hold_o && !code_vma));
    // R2
    mdbusy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        md_busy |-> (&hold_o && !code_vma));
    // R3
    served_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o[0] && !hold_o[WB]) |=> ilock_q);
    // R4
    no_double_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilock_q |-> !(hold_o[0] && !hold_o[WB]));
    // R6
    disabled_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!INTERLOCK_EN && hold_o[0]) |-> hold_o[WB]);
    // R7
    stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stall_q == $past(mem_wait | md_busy)));
endmodule

bind pstall_ctrl pstall_ctrl_chk #(.INTERLOCK_EN(INTERLOCK_EN), .NSTAGE(NSTAGE)) u_chk (.*);

// File: tb/sim_pstall_ctrl.sv
module sim_pstall_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_wait = 1'b0, md_busy = 1'b0, ld_s1 = 1'b0;
    logic [2:0] hold_a, hold_b;
    logic vma_a, vma_b, stl_a, stl_b, ilk_a, ilk_b;
    int checks = 0, fails = 0;
    logic m_ilk = 1'b0, m_stall = 1'b0;

    always #5 clk = ~clk;

    pstall_ctrl #(.INTERLOCK_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_wait(mem_wait), .md_busy(md_busy),
        .ld_s1(ld_s1), .hold_o(hold_a), .code_vma(vma_a), .stall_q(stl_a), .ilock_q(ilk_a));

    pstall_ctrl #(.INTERLOCK_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .mem_wait(mem_wait), .md_busy(md_busy),
        .ld_s1(ld_s1), .hold_o(hold_b), .code_vma(vma_b), .stall_q(stl_b), .ilock_q(ilk_b));

    function automatic logic [2:0] exp_hold(input logic en, input logic ilk);
        logic fr = mem_wait | md_busy;
        logic lk = en & ld_s1 & ~ilk;
        return {fr, fr | lk, fr | lk};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tag_of(output string t);
        if (mem_wait) t = "R1";
        else if (md_busy) t = "R2";
        else if (ld_s1 && !m_ilk) t = "R3/R5";
        else if (m_ilk) t = "R4";
        else t = "R8";
    endtask

    // drive at negedge, check, then advance model at posedge
    task automatic step(input logic mw, input logic md, input logic ld);
        string t;
        @(negedge clk);
        mem_wait = mw; md_busy = md; ld_s1 = ld;
        #1;
        tag_of(t);
        chk(t, {5'd0, hold_a}, {5'd0, exp_hold(1'b1, m_ilk)});
        chk(t, {7'd0, vma_a}, {7'd0, ~exp_hold(1'b1, m_ilk) >> 0 & 1'b1});
        chk("R4 flag", {7'd0, ilk_a}, {7'd0, m_ilk});
        chk("R7", {7'd0, stl_a}, {7'd0, m_stall});
        // R6: disabled instance ignores ld_s1
        chk("R6", {4'd0, vma_b, hold_b}, {4'd0, ~(mw | md), {3{mw | md}}});
        chk("R6 flag", {6'd0, ilk_b, stl_b}, {6'd0, 1'b0, m_stall});
        @(posedge clk);
        m_ilk   = ld & ~m_ilk & ~(mw | md);
        m_stall = mw | md;
    endtask

    initial begin
        #200000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        chk("R8", {4'd0, ilk_a, stl_a, ilk_b, stl_b}, 8'd0);
        chk("R8", {4'd0, vma_a, hold_a}, 8'h08);
        // R3 single load, R4 held load does not relock
        step(0, 0, 1); step(0, 0, 1); step(0, 0, 0);
        // R5 load during memory wait, then wait drops
        step(1, 0, 1); step(1, 0, 1); step(0, 0, 1); step(0, 0, 1); step(0, 0, 0);
        // R5 with multiply busy
        step(0, 1, 1); step(0, 0, 1); step(0, 0, 0);
        // R1 R2 both freezes
        step(1, 1, 0); step(1, 1, 1); step(0, 0, 0);
        for (int i = 0; i < 3000; i++)
            step(($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 3) == 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule